// File: doc/BRIEF.md
# Top-Region Write Lock Controller

This block guards the uppermost 256 bytes of a 16K-byte serial memory array. It sits beside the serial bus slave and watches the decoded transaction stream: START and STOP pulses, and a pulse for each received byte. When one transaction carries the arming pattern, the block sets a sticky lock bit at the closing STOP. The pattern is a device byte of 0xAC, then an address byte whose two top bits are both one, then at least two more bytes. From then on, the top region is read-only. The rest of the array stays writable.

The block also merges the lock with the external write-protect input into one combinational write-enable, `wr_allow`, for the byte address being committed. The memory controller still acknowledges a refused write on the bus but does not commit it. Reads are never gated. No status is exposed. Software can only learn the lock state by writing into the region and reading the data back. Retention of the lock across power cycles is modelled as a register that only reset clears.

Top module: `otp_lock_ctrl`

## Requirements
- R1: After reset the lock is clear, and with `wp_in` low `wr_allow` is 1 for every address, including 0x3F00..0x3FFF.
- R2: While `wp_in` is 1, `wr_allow` is 0 for every address, whether the lock is set or clear.
- R3: A transaction made of START, byte 0xAC, a byte with bits [7:6] = 2'b11, any two or more further bytes and then STOP sets the lock. The lock takes effect in the cycle after the STOP pulse.
- R4: With the lock set and `wp_in` low, `wr_allow` is 0 when address bits [13:8] are all ones (0x3F00 and 0x3FFF) and 1 below that (0x3EFF, 0x0000).
- R5: A first byte other than 0xAC (for example 0xA0 or 0xAD) never sets the lock.
- R6: A second byte whose bits [7:6] are not 2'b11 (for example 0x7F or 0xBF) never sets the lock.
- R7: A STOP that arrives after fewer than four bytes of an otherwise valid pattern does not set the lock.
- R8: The lock never changes in the middle of a transaction. After all bytes of a valid pattern but before its STOP, the region is still writable.
- R9: A repeated START discards the bytes received so far, and matching starts again from the next byte.
- R10: Once the lock is set, only reset clears it. Later transactions, STOPs, and bytes received outside a transaction leave it set.
- R11: Arming works the same whether `wp_in` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the lock |
| start_seen | input | 1 | One-cycle pulse for a bus START or repeated START |
| stop_seen | input | 1 | One-cycle pulse for a bus STOP |
| byte_valid | input | 1 | One-cycle pulse when a full byte has been received |
| byte_data | input | 8 | The received byte, valid with `byte_valid` |
| wp_in | input | 1 | External write-protect; high inhibits all writes |
| wr_addr | input | 14 | Word address of the byte about to be committed |
| wr_allow | output | 1 | 1 when the byte at `wr_addr` may be committed |

## Verification
The closing STOP of an arming sequence and a write-permission query for an address in the top region can occur in the same cycle. The bench provokes this by holding `wr_addr` at 0x3F00 while it pulses the final STOP. It expects `wr_allow` = 1 while the STOP is asserted and 0 from the next cycle on. The same query is also made just before the STOP, with every pattern byte already received, to show that nothing switches early.

// File: rtl/otp_lock_ctrl.sv
module otp_lock_ctrl #(
  parameter int         ADDR_W    = 14,
  parameter int         REGION_W  = 8,
  parameter logic [7:0] ARM_CODE  = 8'hAC,
  parameter int         MIN_BYTES = 4,
  localparam int        CNT_W     = $clog2(MIN_BYTES + 1),
  localparam int        TOP_W     = ADDR_W - REGION_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_seen,
  input  logic              stop_seen,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              wp_in,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              wr_allow
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_BYTES);

  logic             in_xfer;
  logic             match_ok;
  logic [CNT_W-1:0] nbytes;
  logic             locked;

  wire in_region = &wr_addr[ADDR_W-1:REGION_W];
  wire arm_now   = stop_seen && in_xfer && match_ok && (nbytes == CNT_MAX);

  logic unused_low;
  assign unused_low = ^wr_addr[REGION_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_xfer  <= 1'b0;
      match_ok <= 1'b0;
      nbytes   <= '0;
    end else if (stop_seen) begin
      in_xfer  <= 1'b0;
      match_ok <= 1'b0;
      nbytes   <= '0;
    end else if (start_seen) begin
      in_xfer  <= 1'b1;
      match_ok <= 1'b1;
      nbytes   <= '0;
    end else if (byte_valid && in_xfer) begin
      if (nbytes == '0)
        match_ok <= match_ok && (byte_data == ARM_CODE);
      else if (nbytes == CNT_W'(1))
        match_ok <= match_ok && (byte_data[7:6] == 2'b11);
      if (nbytes != CNT_MAX)
        nbytes <= nbytes + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked <= 1'b0;
    else if (arm_now) locked <= 1'b1;
  end

  assign wr_allow = !wp_in && !(locked && in_region);

  // R10: lock is sticky
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R3 / R8: the lock only rises right after a STOP pulse
  a_r3_rise_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(stop_seen));

  // R8: no STOP this cycle means no lock change next cycle
  a_r8_no_mid_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !stop_seen) |=> !locked);

  // R7: a short transaction cannot arm
  a_r7_short_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && stop_seen && nbytes != CNT_MAX) |=> !locked);

  // R4: locked region refuses writes
  a_r4_region_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && in_region) |-> !wr_allow);

  // R2: write-protect refuses everything
  a_r2_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wp_in |-> !wr_allow);

endmodule

// File: tb/tb_otp_lock_ctrl.sv
module tb_otp_lock_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start_seen = 0, stop_seen = 0, byte_valid = 0;
  logic [7:0]  byte_data = 0;
  logic        wp_in = 0;
  logic [13:0] wr_addr = 0;
  logic        wr_allow;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  otp_lock_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .stop_seen(stop_seen),
    .byte_valid(byte_valid), .byte_data(byte_data), .wp_in(wp_in),
    .wr_addr(wr_addr), .wr_allow(wr_allow)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 0; start_seen = 0; stop_seen = 0; byte_valid = 0; wp_in = 0;
    tick; tick;
    rst_n = 1;
    tick;
  endtask

  task automatic go_start;
    start_seen = 1; tick; start_seen = 0;
  endtask

  task automatic go_stop;
    stop_seen = 1; tick; stop_seen = 0;
  endtask

  task automatic go_byte(input logic [7:0] b);
    byte_data = b; byte_valid = 1; tick; byte_valid = 0;
  endtask

  task automatic check(input string req, input logic [13:0] a, input logic wp, input logic exp);
    wr_addr = a; wp_in = wp;
    #1;
    total++;
    if (wr_allow !== exp) begin
      bad++;
      $display("FAIL %s addr=%h wp=%b actual=%b expected=%b", req, a, wp, wr_allow, exp);
    end
    wp_in = 0;
  endtask

  task automatic arm_seq;
    go_start; go_byte(8'hAC); go_byte(8'hC0); go_byte(8'h00); go_byte(8'h5A); go_stop;
  endtask

  task automatic t_reset;
    do_reset;
    check("R1", 14'h3F00, 0, 1);
    check("R1", 14'h3FFF, 0, 1);
    check("R1", 14'h0000, 0, 1);
  endtask

  task automatic t_wp;
    do_reset;
    check("R2", 14'h0123, 1, 0);
    check("R2", 14'h3F80, 1, 0);
    arm_seq;
    check("R2", 14'h0123, 1, 0);
    check("R2", 14'h3F80, 1, 0);
  endtask

  task automatic t_arm_boundaries;
    do_reset;
    go_start; go_byte(8'hAC); go_byte(8'hFF); go_byte(8'h12); go_byte(8'h34);
    check("R8", 14'h3F00, 0, 1);
    wr_addr = 14'h3F00;
    stop_seen = 1;
    #1;
    total++;
    if (wr_allow !== 1'b1) begin
      bad++; $display("FAIL R3 during STOP actual=%b expected=1", wr_allow);
    end
    tick; stop_seen = 0;
    check("R3", 14'h3F00, 0, 0);
    check("R4", 14'h3FFF, 0, 0);
    check("R4", 14'h3EFF, 0, 1);
    check("R4", 14'h0000, 0, 1);
  endtask

  task automatic t_bad_device;
    do_reset;
    go_start; go_byte(8'hA0); go_byte(8'hC0); go_byte(8'h00); go_byte(8'h00); go_stop;
    check("R5", 14'h3F00, 0, 1);
    go_start; go_byte(8'hAD); go_byte(8'hC0); go_byte(8'h00); go_byte(8'h00); go_stop;
    check("R5", 14'h3F00, 0, 1);
  endtask

  task automatic t_bad_tag;
    do_reset;
    go_start; go_byte(8'hAC); go_byte(8'h7F); go_byte(8'h00); go_byte(8'h00); go_stop;
    check("R6", 14'h3FFF, 0, 1);
    go_start; go_byte(8'hAC); go_byte(8'hBF); go_byte(8'h00); go_byte(8'h00); go_stop;
    check("R6", 14'h3FFF, 0, 1);
  endtask

  task automatic t_short;
    do_reset;
    go_start; go_byte(8'hAC); go_byte(8'hC0); go_byte(8'h00); go_stop;
    check("R7", 14'h3F00, 0, 1);
    go_start; go_byte(8'hAC); go_byte(8'hC0); go_stop;
    check("R7", 14'h3F00, 0, 1);
  endtask

  task automatic t_restart;
    do_reset;
    go_start; go_byte(8'hAC); go_byte(8'hC0);
    go_start; go_byte(8'hA0); go_byte(8'h00); go_byte(8'h00); go_byte(8'h00); go_stop;
    check("R9", 14'h3F00, 0, 1);
    go_start; go_byte(8'hA0);
    go_start; go_byte(8'hAC); go_byte(8'hC3); go_byte(8'h00); go_byte(8'h00); go_stop;
    check("R9", 14'h3F00, 0, 0);
  endtask

  task automatic t_sticky;
    do_reset;
    go_byte(8'hAC); go_byte(8'hC0); go_byte(8'h00); go_byte(8'h00); go_stop;
    check("R10", 14'h3F00, 0, 1);
    arm_seq;
    go_start; go_byte(8'hA0); go_byte(8'h00); go_stop;
    go_stop;
    go_byte(8'h00);
    check("R10", 14'h3F40, 0, 0);
    do_reset;
    check("R10", 14'h3F40, 0, 1);
  endtask

  task automatic t_arm_with_wp;
    do_reset;
    wp_in = 1;
    go_start; go_byte(8'hAC); go_byte(8'hC0); go_byte(8'h00); go_byte(8'h00); go_stop;
    wp_in = 0;
    check("R11", 14'h3F10, 0, 0);
    check("R11", 14'h1000, 0, 1);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset;
    t_wp;
    t_arm_boundaries;
    t_bad_device;
    t_bad_tag;
    t_short;
    t_restart;
    t_sticky;
    t_arm_with_wp;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule